// File: doc/BRIEF.md
# Transmit Packet Queue Controller

This block sits between host software and a MAC and manages the order in which stored packets are sent. Software names a packet by a small packet number. An enqueue command places that number at the tail of a transmit queue. While transmission is enabled, the head of the queue is offered to the MAC. In half duplex the offer also waits until the deferral process allows it. The MAC reports the end of each transmission with a completion strobe that carries its result. The block then writes a status word for the packet's first memory word and moves the packet number into a completion queue.

A non-empty completion queue holds the transmit interrupt high. Software acknowledges one entry at a time. A failed transmission clears the enable, so the queue stops with the failing packet at the head of the completion queue, where software can read it. Setting the enable again resumes with the next pending packet. Both queue heads and their empty flags are always readable on a packed FIFO ports word.

The MAC offer is a valid/ready stream. `mac_valid` is a readiness indication and not a commitment: it drops if enable clears or deferral starts before the MAC accepts. A transfer happens only on a cycle where `mac_valid` and `mac_ready` are both high. After a transfer the block makes no further offer until a completion arrives. The MAC may hold `mac_ready` low for as long as it needs.

Top module: `txq_ctrl`

## Requirements
- R1: A high `enq_cmd` at a clock edge appends `enq_pnum` to the tail of the transmit queue. Packet numbers leave the queue in the order they were enqueued.
- R2: `mac_valid` is high only when all of these hold: `txen` is 1, the transmit queue is non-empty, no packet is in flight, and the completion queue is not full. `mac_pnum` is the transmit queue head. A `mac_valid && mac_ready` edge marks that packet in flight, and no new offer is made until its completion.
- R3: While `half_duplex` is 1 and `defer_busy` is 1, `mac_valid` is 0. While `half_duplex` is 0, `defer_busy` has no effect.
- R4: A `done_valid` edge while a packet is in flight removes the head from the transmit queue and appends it to the completion queue.
- R5: In the cycle after that completion edge, `stat_we` is 1 for exactly one cycle and `stat_pnum` is the completed packet. `stat_word` holds `done_ok` in bit 15, `done_coll` in bits 6:3 and `done_err` in bits 2:0, with all other bits 0.
- R6: `tx_int` is 1 exactly when the completion queue is non-empty.
- R7: An `int_ack` edge removes the completion queue head. `int_ack` while that queue is empty has no effect.
- R8: A completion with `done_ok` = 0 clears `txen` at that edge, so no further packet is offered. The failing packet number becomes readable in the completion head field once earlier entries are acknowledged. A later `txen_set` resumes offering from the next pending packet.
- R9: An `enq_cmd` while the transmit queue holds 16 entries is dropped and sets `ovf_flag`. The flag stays set until `ovf_clr`, and a new overflow in the same cycle wins over `ovf_clr`.
- R10: A `done_valid` with no packet in flight has no effect on the queues, `txen` or `stat_we`.
- R11: `fifo_ports` layout: bit 9 is completion-empty, bits 8:5 are the completion head, bit 4 is transmit-empty, and bits 3:0 are the transmit head. A head field reads 0 while its queue is empty.
- R12: After reset, `txen`, `mac_valid`, `stat_we`, `tx_int` and `ovf_flag` are 0, and `fifo_ports` is 0x210.
- R13: `txen_set` sets `txen` and `txen_clr` clears it. When both are high, the clear wins, and a failure completion also wins over `txen_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_cmd | input | 1 | Enqueue command strobe |
| enq_pnum | input | 4 | Packet number to enqueue |
| txen_set | input | 1 | Set transmit enable |
| txen_clr | input | 1 | Clear transmit enable |
| txen | output | 1 | Transmit enable state |
| half_duplex | input | 1 | 1 = half duplex, deferral applies |
| defer_busy | input | 1 | Deferral process is holding off transmission |
| mac_valid | output | 1 | Packet offered to the MAC |
| mac_ready | input | 1 | MAC accepts the offered packet |
| mac_pnum | output | 4 | Offered packet number |
| done_valid | input | 1 | MAC completion strobe |
| done_ok | input | 1 | Completion succeeded |
| done_coll | input | 4 | Collision count of the completion |
| done_err | input | 3 | Error code of the completion |
| stat_we | output | 1 | Status word write strobe for packet memory |
| stat_pnum | output | 4 | Packet whose first word is written |
| stat_word | output | 16 | Status word to write |
| int_ack | input | 1 | Transmit interrupt acknowledge write |
| tx_int | output | 1 | Transmit interrupt |
| fifo_ports | output | 10 | Queue heads and empty flags |
| ovf_clr | input | 1 | Clear the overflow flag |
| ovf_flag | output | 1 | Sticky enqueue overflow flag |

## Verification
Every queue, enable and flag change caused by a strobe appears right after the clock edge that samples that strobe. `mac_valid` reacts combinationally to the enable, the deferral inputs and the queue state. The status write strobe lands one cycle later, in the cycle that follows the completion edge. The bench drives inputs on the falling edge and reads queue and flag results a short delay after the next falling edge. A monitor samples just after each falling edge, so it sees the handshakes and status writes that the next rising edge acts on. The monitor compares each offered packet number and each status write against scoreboard queues that the driver fills in issue order.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int PNUM_W_DEF = 4;
  localparam int DEPTH_DEF  = 16;
  localparam int COLL_W_DEF = 4;
  localparam int ERR_W_DEF  = 3;
  localparam int STAT_W_DEF = 16;

  typedef enum logic {
    TXS_IDLE = 1'b0,
    TXS_BUSY = 1'b1
  } txs_e;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/txq_sched.sv
module txq_sched
  import txq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_set,
  input  logic en_clr,
  input  logic have_pkt,
  input  logic room_done,
  input  logic half_duplex,
  input  logic defer_busy,
  input  logic mac_ready,
  input  logic done_valid,
  input  logic done_ok,
  output logic txen,
  output logic mac_valid,
  output logic in_flight,
  output logic complete
);
  txs_e state;
  logic defer_hold;
  logic fail_evt;

  assign in_flight  = (state == TXS_BUSY);
  assign complete   = done_valid && in_flight;
  assign fail_evt   = complete && !done_ok;
  assign defer_hold = half_duplex && defer_busy;
  assign mac_valid  = txen && !in_flight && have_pkt && room_done && !defer_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txen <= 1'b0;
    end else if (fail_evt || en_clr) begin
      txen <= 1'b0;
    end else if (en_set) begin
      txen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TXS_IDLE;
    end else begin
      case (state)
        TXS_IDLE: if (mac_valid && mac_ready) state <= TXS_BUSY;
        TXS_BUSY: if (done_valid)             state <= TXS_IDLE;
        default:                              state <= TXS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txq_status.sv
module txq_status #(
  parameter int PNUM_W = 4,
  parameter int COLL_W = 4,
  parameter int ERR_W  = 3,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              complete,
  input  logic [PNUM_W-1:0] pnum,
  input  logic              ok,
  input  logic [COLL_W-1:0] coll,
  input  logic [ERR_W-1:0]  err,
  output logic              stat_we,
  output logic [PNUM_W-1:0] stat_pnum,
  output logic [STAT_W-1:0] stat_word
);
  logic [STAT_W-1:0] packed_word;

  always_comb begin
    packed_word                          = '0;
    packed_word[STAT_W-1]                = ok;
    packed_word[ERR_W+COLL_W-1:ERR_W]    = coll;
    packed_word[ERR_W-1:0]               = err;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_we   <= 1'b0;
      stat_pnum <= '0;
      stat_word <= '0;
    end else begin
      stat_we <= complete;
      if (complete) begin
        stat_pnum <= pnum;
        stat_word <= packed_word;
      end
    end
  end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int PNUM_W = PNUM_W_DEF,
  parameter int DEPTH  = DEPTH_DEF,
  parameter int COLL_W = COLL_W_DEF,
  parameter int ERR_W  = ERR_W_DEF,
  parameter int STAT_W = STAT_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enq_cmd,
  input  logic [PNUM_W-1:0]     enq_pnum,
  input  logic                  txen_set,
  input  logic                  txen_clr,
  output logic                  txen,
  input  logic                  half_duplex,
  input  logic                  defer_busy,
  output logic                  mac_valid,
  input  logic                  mac_ready,
  output logic [PNUM_W-1:0]     mac_pnum,
  input  logic                  done_valid,
  input  logic                  done_ok,
  input  logic [COLL_W-1:0]     done_coll,
  input  logic [ERR_W-1:0]      done_err,
  output logic                  stat_we,
  output logic [PNUM_W-1:0]     stat_pnum,
  output logic [STAT_W-1:0]     stat_word,
  input  logic                  int_ack,
  output logic                  tx_int,
  output logic [2*PNUM_W+1:0]   fifo_ports,
  input  logic                  ovf_clr,
  output logic                  ovf_flag
);
  logic [PNUM_W-1:0] tx_head, cq_head;
  logic              tx_empty, tx_full;
  logic              cq_empty, cq_full;
  logic              in_flight, complete;

  txq_fifo #(.W(PNUM_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(enq_cmd), .din(enq_pnum), .pop(complete),
    .head(tx_head), .empty(tx_empty), .full(tx_full)
  );

  txq_fifo #(.W(PNUM_W), .DEPTH(DEPTH)) u_cq (
    .clk(clk), .rst_n(rst_n),
    .push(complete), .din(tx_head), .pop(int_ack),
    .head(cq_head), .empty(cq_empty), .full(cq_full)
  );

  txq_sched u_sched (
    .clk(clk), .rst_n(rst_n),
    .en_set(txen_set), .en_clr(txen_clr),
    .have_pkt(!tx_empty), .room_done(!cq_full),
    .half_duplex(half_duplex), .defer_busy(defer_busy),
    .mac_ready(mac_ready), .done_valid(done_valid), .done_ok(done_ok),
    .txen(txen), .mac_valid(mac_valid),
    .in_flight(in_flight), .complete(complete)
  );

  txq_status #(.PNUM_W(PNUM_W), .COLL_W(COLL_W), .ERR_W(ERR_W), .STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .complete(complete), .pnum(tx_head),
    .ok(done_ok), .coll(done_coll), .err(done_err),
    .stat_we(stat_we), .stat_pnum(stat_pnum), .stat_word(stat_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
    end else if (enq_cmd && tx_full) begin
      ovf_flag <= 1'b1;
    end else if (ovf_clr) begin
      ovf_flag <= 1'b0;
    end
  end

  assign mac_pnum   = tx_head;
  assign tx_int     = !cq_empty;
  assign fifo_ports = {cq_empty, cq_head, tx_empty, tx_head};
endmodule

// File: rtl/txq_ctrl_chk.sv
module txq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic txen,
  input logic mac_valid,
  input logic half_duplex,
  input logic defer_busy,
  input logic done_valid,
  input logic done_ok,
  input logic in_flight,
  input logic stat_we,
  input logic tx_int,
  input logic enq_cmd,
  input logic tx_full,
  input logic ovf_flag
);
  assert_offer_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mac_valid |-> txen);

  assert_defer_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (half_duplex && defer_busy) |-> !mac_valid);

  assert_stat_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && in_flight) |=> stat_we);

  assert_int_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && in_flight) |=> tx_int);

  assert_fail_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && in_flight && !done_ok) |=> (!txen && !mac_valid));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_cmd && tx_full) |=> ovf_flag);

  assert_spurious_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !in_flight) |=> !stat_we);
endmodule

bind txq_ctrl txq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txen(txen), .mac_valid(mac_valid),
  .half_duplex(half_duplex), .defer_busy(defer_busy),
  .done_valid(done_valid), .done_ok(done_ok), .in_flight(in_flight),
  .stat_we(stat_we), .tx_int(tx_int), .enq_cmd(enq_cmd),
  .tx_full(tx_full), .ovf_flag(ovf_flag)
);

// File: tb/tb_txq_ctrl.sv
`timescale 1ns/1ps
module tb_txq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        enq_cmd = 0, txen_set = 0, txen_clr = 0, half_duplex = 0, defer_busy = 0;
  logic        mac_ready = 0, done_valid = 0, done_ok = 0, int_ack = 0, ovf_clr = 0;
  logic [3:0]  enq_pnum = 0, done_coll = 0;
  logic [2:0]  done_err = 0;
  logic        txen, mac_valid, stat_we, tx_int, ovf_flag;
  logic [3:0]  mac_pnum, stat_pnum;
  logic [15:0] stat_word;
  logic [9:0]  fifo_ports;

  txq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .enq_cmd(enq_cmd), .enq_pnum(enq_pnum),
    .txen_set(txen_set), .txen_clr(txen_clr), .txen(txen),
    .half_duplex(half_duplex), .defer_busy(defer_busy),
    .mac_valid(mac_valid), .mac_ready(mac_ready), .mac_pnum(mac_pnum),
    .done_valid(done_valid), .done_ok(done_ok), .done_coll(done_coll), .done_err(done_err),
    .stat_we(stat_we), .stat_pnum(stat_pnum), .stat_word(stat_word),
    .int_ack(int_ack), .tx_int(tx_int), .fifo_ports(fifo_ports),
    .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
  );

  int unsigned n_checks = 0, n_fail = 0;
  bit finished = 0;
  int exp_mac[$];
  logic [19:0] exp_stat[$];
  logic [3:0] last_hs = 0;
  int tx_cnt = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] ports(logic de, logic [3:0] dh, logic te, logic [3:0] th);
    return {de, dh, te, th};
  endfunction

  // Monitor: compares handshakes and status writes with the scoreboard
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (mac_valid && mac_ready) begin
          if (exp_mac.size() == 0) check("R2 unexpected offer", 32'(mac_pnum), 32'hFFFF);
          else check("R1 R2 offer order", 32'(mac_pnum), 32'(exp_mac.pop_front()));
          last_hs = mac_pnum;
        end
        if (stat_we) begin
          if (exp_stat.size() == 0) check("R5 R10 unexpected status write", 32'(stat_pnum), 32'hFFFF);
          else check("R5 status write", {12'h0, stat_pnum, stat_word}, 32'(exp_stat.pop_front()));
        end
      end
    end
  end

  task automatic settle(); #2; endtask

  task automatic do_enq(logic [3:0] p);
    @(negedge clk); enq_cmd = 1; enq_pnum = p;
    if (tx_cnt < 16) begin exp_mac.push_back(int'(p)); tx_cnt++; end
    @(negedge clk); enq_cmd = 0; settle();
  endtask

  task automatic do_set(logic s, logic c);
    @(negedge clk); txen_set = s; txen_clr = c;
    @(negedge clk); txen_set = 0; txen_clr = 0; settle();
  endtask

  task automatic do_hs();
    @(negedge clk); mac_ready = 1;
    @(negedge clk); mac_ready = 0; settle();
  endtask

  task automatic do_done(logic ok, logic [3:0] coll, logic [2:0] err, bit expect_write);
    @(negedge clk); done_valid = 1; done_ok = ok; done_coll = coll; done_err = err;
    if (expect_write) begin
      exp_stat.push_back({last_hs, ok, 8'h00, coll, err});
      tx_cnt--;
    end
    @(negedge clk); done_valid = 0; done_ok = 0; settle();
  endtask

  task automatic do_ack();
    @(negedge clk); int_ack = 1;
    @(negedge clk); int_ack = 0; settle();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; settle();
    // R12 reset state
    check("R12 txen", 32'(txen), 0);
    check("R12 mac_valid", 32'(mac_valid), 0);
    check("R12 tx_int", 32'(tx_int), 0);
    check("R12 ovf", 32'(ovf_flag), 0);
    check("R12 R11 ports", 32'(fifo_ports), 32'h210);

    do_enq(4'd3); do_enq(4'd7); do_enq(4'd12);
    check("R1 R11 head after enqueue", 32'(fifo_ports), 32'(ports(1, 0, 0, 3)));
    check("R2 no offer while disabled", 32'(mac_valid), 0);

    do_set(1, 0);
    check("R13 set enable", 32'(txen), 1);
    check("R2 offer", 32'(mac_valid), 1);
    check("R2 offer pnum", 32'(mac_pnum), 3);

    @(negedge clk); half_duplex = 1; defer_busy = 1; settle();
    check("R3 half duplex deferral blocks", 32'(mac_valid), 0);
    @(negedge clk); half_duplex = 0; settle();
    check("R3 full duplex ignores deferral", 32'(mac_valid), 1);
    @(negedge clk); defer_busy = 0; settle();

    do_hs();
    check("R2 no offer while in flight", 32'(mac_valid), 0);
    do_done(1, 4'd2, 3'd0, 1);
    check("R4 R11 move to completion", 32'(fifo_ports), 32'(ports(0, 3, 0, 7)));
    check("R6 interrupt", 32'(tx_int), 1);

    do_done(0, 4'd1, 3'd1, 0);  // nothing in flight
    check("R10 spurious done ports", 32'(fifo_ports), 32'(ports(0, 3, 0, 7)));
    check("R10 spurious done txen", 32'(txen), 1);

    do_hs();
    do_done(0, 4'd5, 3'd3, 1);
    check("R8 failure clears txen", 32'(txen), 0);
    check("R8 failure stops offers", 32'(mac_valid), 0);
    check("R8 ports after failure", 32'(fifo_ports), 32'(ports(0, 3, 0, 12)));
    do_ack();
    check("R7 R8 failing pnum exposed", 32'(fifo_ports), 32'(ports(0, 7, 0, 12)));
    check("R6 interrupt held", 32'(tx_int), 1);
    do_ack();
    check("R7 completion emptied", 32'(fifo_ports), 32'(ports(1, 0, 0, 12)));
    check("R6 interrupt cleared", 32'(tx_int), 0);
    do_ack();
    check("R7 ack on empty ignored", 32'(fifo_ports), 32'(ports(1, 0, 0, 12)));

    do_set(1, 0);
    check("R8 resume offer", 32'(mac_valid), 1);
    check("R8 resume pnum", 32'(mac_pnum), 12);
    do_set(1, 1);
    check("R13 clear wins over set", 32'(txen), 0);

    for (int i = 0; i < 15; i++) do_enq(4'(i));
    check("R9 no overflow at 16", 32'(ovf_flag), 0);
    do_enq(4'd9);
    check("R9 overflow flag", 32'(ovf_flag), 1);
    check("R9 head unchanged", 32'(fifo_ports), 32'(ports(1, 0, 0, 12)));
    @(negedge clk); settle();
    check("R9 overflow sticky", 32'(ovf_flag), 1);
    @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0; settle();
    check("R9 overflow cleared", 32'(ovf_flag), 0);

    do_set(1, 0);
    for (int i = 0; i < 16; i++) begin
      do_hs();
      do_done(1, 4'(i), 3'(i), 1);
    end
    check("R9 dropped entry absent", 32'(fifo_ports), 32'(ports(0, 12, 1, 0)));
    check("R6 interrupt with full completion", 32'(tx_int), 1);

    do_enq(4'd5);
    check("R2 completion full blocks offer", 32'(mac_valid), 0);
    do_ack();
    check("R2 offer after room", 32'(mac_valid), 1);
    check("R2 offer pnum after room", 32'(mac_pnum), 5);
    check("R7 next completion head", 32'(fifo_ports), 32'(ports(0, 0, 0, 5)));
    do_hs();
    do_done(1, 4'd15, 3'd7, 1);
    for (int i = 0; i < 16; i++) do_ack();
    check("R7 all acknowledged", 32'(fifo_ports), 32'h210);
    check("R6 interrupt low at end", 32'(tx_int), 0);
    repeat (2) @(negedge clk);
    check("R1 all offers seen", 32'(exp_mac.size()), 0);
    check("R5 all status writes seen", 32'(exp_stat.size()), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule